// File: doc/BRIEF.md
# Raster-to-Macroblock Reorderer with One Line Buffer

This block takes a video frame arriving in raster order and hands it on in macroblock order, for a transform stage that works one macroblock at a time. Each transfer on either side carries one macroblock-row word: the pixels of one row of one macroblock, packed together. The frame width is a whole number of macroblocks (`MB_W`). A macroblock is `MB_H` rows tall, and a frame holds `MB_LINES` macroblock-lines. One macroblock-line therefore holds N = `MB_W`·`MB_H` words.

Storage is a single dual-port RAM of N words. The first macroblock-line of a frame is written straight into slots 0..N-1. Each later operation reads one slot and, in the same cycle, writes the next arriving word into that slot. A generator steps the shared address by a stride. A sum above N-1 is reduced by N-1. The stride for each new macroblock-line is taken from the address the previous line used at operation index `MB_W`. After the last line, the buffer drains with reads only, and the block returns to the fill state with a stride of 1.

Both sides use valid/ready handshakes. Once the fill is done, reads and writes are paired, so each side can stall the other.

Top module: `raster_mb_reorder`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block enters its fill state: `out_valid` is low and `in_ready` is high.
- R2: During the fill of a frame's first macroblock-line, `in_ready` stays high. No word of that frame is presented at the output until all N of its first-line words have been accepted.
- R3: Within a macroblock-line, output k (0-based) is the input word with line-local raster index (k mod `MB_H`)·`MB_W` + floor(k / `MB_H`). So macroblocks come out left to right, each with its rows top to bottom.
- R4: Only N words are stored. Each slot read during a macroblock-line is refilled in the same operation with a word of the next line, and the word read is the one held before that write.
- R5: The address starts at 0 for every line and moves by the stride. A sum above N-1 becomes the sum minus (N-1), so every address lies in 0..N-1. The next line's stride is the address used at operation index `MB_W`. The ordering of R3 holds on every line of a frame, over a full repeat of the stride sequence.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold. After the first line of a frame, `in_ready` is high exactly when the output register is empty or being taken.
- R7: Once all `MB_LINES`·N words of a frame are accepted, `in_ready` stays low until the last N words have been read out.
- R8: After a drain, the next frame starts again with a fill and a stride of 1, and is reordered exactly like the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Raster-order word offered |
| in_ready | output | 1 | Block accepts the offered word |
| in_data | input | DW | Incoming macroblock-row word |
| out_valid | output | 1 | Macroblock-order word presented |
| out_ready | input | 1 | Downstream takes the presented word |
| out_data | output | DW | Outgoing macroblock-row word |

## Verification
The assertions assume that reset is asserted before the first useful edge, and that `MB_H` is at least 2, so that operation index `MB_W` falls inside a line. They also assume the upstream keeps offering words in raster order without gaps in frame structure, so that every frame is exactly `MB_LINES` lines long. The stimulus first holds reset low for several cycles. It then sends whole frames only, tagging each word with its frame, line and raster index. It throttles `in_valid` and `out_ready` with different periodic patterns, including long output stalls, so that both paired and one-sided stalls occur inside the limits the checks assume.

// File: rtl/rmb_pkg.sv
`timescale 1ns/1ps
// Shared types for the raster-to-macroblock reorderer.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package rmb_pkg;
    // Operating state of the single line buffer.
    typedef enum logic [1:0] {
        PH_FILL  = 2'd0,   // first line of a frame: write only
        PH_SWAP  = 2'd1,   // read a slot and refill it in one operation
        PH_DRAIN = 2'd2    // last line leaving: read only
    } phase_t;
endpackage

// File: rtl/rmb_addr_gen.sv
`timescale 1ns/1ps
// Remap address generator: produces the shared read/write slot address.
// The address advances by a stride. A sum above N-1 is reduced by N-1.
// The stride of the next line is the address used at operation index MB_W.
// Assumes: MB_H >= 2, so index MB_W lies inside a line of N operations.
module rmb_addr_gen #(
    parameter int MB_W = 5,
    parameter int MB_H = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            step,
    input  logic                            restart,
    output logic [$clog2(MB_W*MB_H)-1:0]    addr,
    output logic                            last_op
);
    localparam int          N      = MB_W * MB_H;
    localparam int          AW     = $clog2(N);
    localparam int unsigned LAST   = N - 1;
    localparam logic [AW:0] LAST_X = LAST[AW:0];
    localparam logic [AW-1:0] LAST_A = LAST[AW-1:0];
    localparam logic [AW-1:0] SNAP_I = MB_W[AW-1:0];
    localparam logic [AW-1:0] ONE_A  = {{(AW-1){1'b0}}, 1'b1};

    logic [AW-1:0] addr_q, stride_q, snap_q, cnt_q;
    logic [AW:0]   sum, wrapped;
    logic [AW-1:0] addr_next, stride_next;

    // Next address: add the stride and fold values above N-1.
    always_comb begin
        sum       = {1'b0, addr_q} + {1'b0, stride_q};
        wrapped   = sum - LAST_X;
        addr_next = (sum > LAST_X) ? wrapped[AW-1:0] : sum[AW-1:0];
    end

    // Next-line stride: the snapshot, or the live address if index MB_W is this op.
    assign stride_next = (cnt_q == SNAP_I) ? addr_q : snap_q;
    assign last_op     = (cnt_q == LAST_A);
    assign addr        = addr_q;

    // Step the address, the operation count and the stride once per operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q   <= '0;
            cnt_q    <= '0;
            stride_q <= ONE_A;
            snap_q   <= ONE_A;
        end else if (step) begin
            if (cnt_q == SNAP_I) snap_q <= addr_q;
            if (last_op) begin
                cnt_q    <= '0;
                addr_q   <= '0;
                stride_q <= restart ? ONE_A : stride_next;
            end else begin
                cnt_q  <= cnt_q + ONE_A;
                addr_q <= addr_next;
            end
        end
    end

    // Every slot address stays inside the N-word buffer.
    p_addr_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        addr_q <= LAST_A);
    // A zero stride would revisit one slot forever.
    p_stride_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        stride_q != '0);
    // Consecutive operations inside a line never reuse the same slot.
    p_fresh_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !last_op) |=> (addr_q != $past(addr_q)));
    // A frame restart leaves the next line with unit stride from slot 0.
    p_restart_unit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (step && last_op && restart) |=> (stride_q == ONE_A && addr_q == '0));
endmodule

// File: rtl/rmb_slot_ram.sv
`timescale 1ns/1ps
// Simple dual-port slot RAM with a registered read port.
// A read and a write to the same slot in one cycle return the old word.
// The read register holds its value while no read is issued.
// Assumes: DEPTH <= 2**AW.
module rmb_slot_ram #(
    parameter int DEPTH = 20,
    parameter int AW    = 5,
    parameter int DW    = 16
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [DW-1:0] wd,
    input  logic          re,
    input  logic [AW-1:0] ra,
    output logic [DW-1:0] rd
);
    logic [DW-1:0] mem [DEPTH];

    // Read old contents first, then store the new word (non-blocking order).
    always_ff @(posedge clk) begin
        if (re) rd <= mem[ra];
        if (we) mem[wa] <= wd;
    end
endmodule

// File: rtl/rmb_phase_ctl.sv
`timescale 1ns/1ps
// Frame sequencer: fill for the first line, swap for lines 1..MB_LINES-1,
// then drain, then back to fill for the next frame.
// Assumes: line_done pulses once on the last operation of each line.
module rmb_phase_ctl
    import rmb_pkg::*;
#(
    parameter int MB_LINES = 12
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   line_done,
    output phase_t phase,
    output logic   restart
);
    localparam int LW = (MB_LINES > 1) ? $clog2(MB_LINES) : 1;
    localparam int unsigned LASTL = MB_LINES - 1;
    localparam logic [LW-1:0] LAST_LINE = LASTL[LW-1:0];
    localparam logic [LW-1:0] ONE_L     = {{(LW-1){1'b0}}, 1'b1};

    phase_t        phase_q;
    logic [LW-1:0] line_q;

    // Advance the frame state at the end of each line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_FILL;
            line_q  <= '0;
        end else if (line_done) begin
            unique case (phase_q)
                PH_FILL: begin
                    phase_q <= (MB_LINES > 1) ? PH_SWAP : PH_DRAIN;
                    line_q  <= ONE_L;
                end
                PH_SWAP: begin
                    if (line_q == LAST_LINE) phase_q <= PH_DRAIN;
                    else                     line_q  <= line_q + ONE_L;
                end
                default: begin
                    phase_q <= PH_FILL;
                    line_q  <= '0;
                end
            endcase
        end
    end

    assign phase   = phase_q;
    assign restart = (phase_q == PH_DRAIN);

    // A drain always ends in a fresh fill.
    p_drain_to_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_DRAIN && line_done) |=> (phase_q == PH_FILL));
endmodule

// File: rtl/raster_mb_reorder.sv
`timescale 1ns/1ps
// Raster-order to macroblock-order reorderer using one line of storage.
// Each operation after the first line reads one slot and refills it with
// the next raster word; the output register presents the word read.
// Assumes: MB_H >= 2, MB_LINES >= 1, frames arrive whole and in raster order.
module raster_mb_reorder
    import rmb_pkg::*;
#(
    parameter int MB_W     = 5,
    parameter int MB_H     = 4,
    parameter int MB_LINES = 12,
    parameter int DW       = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [DW-1:0] in_data,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [DW-1:0] out_data
);
    localparam int N  = MB_W * MB_H;
    localparam int AW = $clog2(N);

    phase_t        phase;
    logic          restart, last_op, op, re, we, out_room, out_valid_q;
    logic [AW-1:0] addr;

    // Handshake: pair reads and writes once the fill is done.
    always_comb begin
        out_room = !out_valid_q || out_ready;
        unique case (phase)
            PH_FILL:  begin in_ready = 1'b1;     op = in_valid;             end
            PH_SWAP:  begin in_ready = out_room; op = in_valid && out_room; end
            default:  begin in_ready = 1'b0;     op = out_room;             end
        endcase
        re = op && (phase != PH_FILL);
        we = op && (phase != PH_DRAIN);
    end

    rmb_addr_gen #(.MB_W(MB_W), .MB_H(MB_H)) u_addr (
        .clk(clk), .rst_n(rst_n), .step(op), .restart(restart),
        .addr(addr), .last_op(last_op)
    );

    rmb_phase_ctl #(.MB_LINES(MB_LINES)) u_phase (
        .clk(clk), .rst_n(rst_n), .line_done(op && last_op),
        .phase(phase), .restart(restart)
    );

    rmb_slot_ram #(.DEPTH(N), .AW(AW), .DW(DW)) u_ram (
        .clk(clk), .we(we), .wa(addr), .wd(in_data),
        .re(re), .ra(addr), .rd(out_data)
    );

    // Output valid: set by a read, cleared when taken without a new read.
    always_ff @(posedge clk) begin
        if (!rst_n)         out_valid_q <= 1'b0;
        else if (re)        out_valid_q <= 1'b1;
        else if (out_ready) out_valid_q <= 1'b0;
    end

    assign out_valid = out_valid_q;

    // Reset leaves the output empty and the input open.
    p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!out_valid && in_ready));
    // A stalled output word holds still.
    p_hold_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
    // Outside the fill, a blocked output also blocks the input.
    p_input_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && phase != PH_FILL) |-> !in_ready);
    // During the drain nothing new enters.
    p_drain_closed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DRAIN) |-> !in_ready);
endmodule

// File: tb/tb_raster_mb_reorder.sv
`timescale 1ns/1ps
// One bench lane: drives one configuration of the reorderer and checks it.
module tb_lane #(
    parameter int MB_W     = 5,
    parameter int MB_H     = 4,
    parameter int MB_LINES = 12
) (
    input  logic clk,
    input  logic rst_n,
    output logic done,
    output int   nchk,
    output int   nfail
);
    localparam int DW     = 16;
    localparam int N      = MB_W * MB_H;
    localparam int LN     = N * MB_LINES;
    localparam int FRAMES = 3;
    localparam int TOTAL  = FRAMES * LN;

    logic          in_valid, in_ready, out_valid, out_ready;
    logic [DW-1:0] in_data, out_data;

    raster_mb_reorder #(.MB_W(MB_W), .MB_H(MB_H), .MB_LINES(MB_LINES), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    // Word tag: frame[15:12], line[11:8], line-local raster index[7:0].
    function automatic logic [DW-1:0] tag(int f, int j, int idx);
        return {f[3:0], j[3:0], idx[7:0]};
    endfunction

    function automatic logic [DW-1:0] in_word(int a);
        int rem = a % LN;
        return tag(a / LN, rem / N, rem % N);
    endfunction

    // Expected output e: R3 order, k-th word -> (k mod H)*W + k/H.
    function automatic logic [DW-1:0] out_word(int e);
        int rem = e % LN;
        int k   = rem % N;
        return tag(e / LN, rem / N, (k % MB_H) * MB_W + k / MB_H);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s W=%0d H=%0d actual=%0h expected=%0h",
                     req, MB_W, MB_H, act, exp);
        end
    endtask

    initial begin
        int acc = 0, emi = 0, cyc = 0, reads, fstart;
        bit prev_stall = 0;
        logic [DW-1:0] prev_data = '0;
        string oreq;
        done = 0; nchk = 0; nfail = 0;
        in_valid = 0; out_ready = 0; in_data = '0;
        // R1: reset state observed while reset is held.
        repeat (2) @(negedge clk);
        chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
        chk(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
        wait (rst_n == 1'b1);
        while (emi < TOTAL) begin
            @(negedge clk);
            cyc++;
            // Throttling per frame: free-running, short gaps, long bursts.
            case (emi / LN)
                0:       out_ready = 1'b1;
                1:       out_ready = (cyc % 3) != 0;
                default: out_ready = (cyc % 16) < 8;
            endcase
            case (acc / LN)
                0:       in_valid = (acc < TOTAL);
                1:       in_valid = (cyc % 5) != 1;
                default: in_valid = (acc < TOTAL) && ((cyc % 7) != 3);
            endcase
            in_data = in_word(acc);
            #1;
            reads  = emi + int'(out_valid);
            fstart = acc - (acc % LN);
            if (prev_stall)
                chk(out_valid && out_data == prev_data, "R6 hold", int'(out_data), int'(prev_data));
            if (reads == fstart && (acc % LN) < N)
                chk(in_ready == 1'b1, "R2 fill open", int'(in_ready), 1);
            else if ((acc % LN) == 0 && reads < acc)
                chk(in_ready == 1'b0, "R7 drain closed", int'(in_ready), 0);
            else
                chk(in_ready == (!out_valid || out_ready), "R6 paired ready",
                    int'(in_ready), int'(!out_valid || out_ready));
            prev_stall = out_valid && !out_ready;
            prev_data  = out_data;
            if (out_valid && out_ready) begin
                if (emi >= LN)          oreq = "R8 next frame";
                else if (emi < N)       oreq = "R3 order";
                else if (emi < 2 * N)   oreq = "R4 refill";
                else                    oreq = "R5 stride chain";
                chk(out_data == out_word(emi), oreq, int'(out_data), int'(out_word(emi)));
                chk(acc >= (emi / LN) * LN + N, "R2 no early read", acc, (emi / LN) * LN + N);
                emi++;
            end
            if (in_valid && in_ready) acc++;
        end
        @(negedge clk);
        in_valid = 0; out_ready = 0;
        done = 1;
    end
endmodule

// Top bench: three lanes of different geometry, walked by a generate loop.
module tb_raster_mb_reorder;
    localparam int NCFG = 3;
    // Geometry table: width in macroblocks, macroblock height, lines per frame.
    // Line counts cover a full repeat of each stride sequence.
    localparam int CW [NCFG] = '{5, 3, 4};
    localparam int CH [NCFG] = '{4, 2, 2};
    localparam int CL [NCFG] = '{12, 6, 5};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic done_a [NCFG];
    int   chk_a  [NCFG];
    int   fail_a [NCFG];

    always #2 clk = ~clk;

    for (genvar g = 0; g < NCFG; g++) begin : g_lane
        tb_lane #(.MB_W(CW[g]), .MB_H(CH[g]), .MB_LINES(CL[g])) u_lane (
            .clk(clk), .rst_n(rst_n),
            .done(done_a[g]), .nchk(chk_a[g]), .nfail(fail_a[g])
        );
    end

    initial begin
        int cycles = 0, tot_chk = 0, tot_fail = 0;
        bit all_done = 0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        while (!all_done && cycles < 150000) begin
            @(negedge clk);
            cycles++;
            all_done = 1;
            for (int i = 0; i < NCFG; i++) if (!done_a[i]) all_done = 0;
        end
        for (int i = 0; i < NCFG; i++) begin
            tot_chk  += chk_a[i];
            tot_fail += fail_a[i];
        end
        if (!all_done) begin
            tot_chk++;
            tot_fail++;
            $display("FAIL watchdog actual=%0d expected=done", cycles);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", tot_chk, tot_fail);
        $finish;
    end
endmodule